// File: doc/BRIEF.md
# System Register Access Permission Checker

This block stands beside a processor's system register file and rules on every load or store of a system register. Each request names a register by a 5-bit register number and a 5-bit selection group, says whether it reads or writes, and arrives with the current user-mode flag and the three coprocessor-enable bits of the status word. A built-in map gives every (number, group) pair a permission class. The checker then either grants the access or raises an exception with a cause code. Exactly one of the two happens, and it is reported one clock after the request.

A granted access can still be neutralised. A write to an unassigned register, or to one of a fixed set of protected register numbers, is dropped, and a drop flag tells the register file. A read of an unassigned register returns zero, with an undefined-read flag. The general-purpose registers and the program counter never pass through this block.

Top module: `sreg_guard`

## Requirements
- R1: Each request with `req_valid_i` high produces, on the next clock edge, exactly one of `grant_o` or `exc_o`. A cycle without a request leaves every output flag low on the next edge, and every output is zero while `rst_n` is low.
- R2: The class map (g = group, n = number) is as follows; every other pair is unassigned.
  - g0: n0–5 supervisor, n6–7 coprocessor-0, n8 coprocessor-0 plus supervisor, n9–11 supervisor.
  - g1: n0–3 user, n4–15 supervisor.
  - g2: n0–7 supervisor, n8 coprocessor-1, n9 coprocessor-2.
  - g3: n0–7 supervisor.
  - g4–g7: n0–15 supervisor.
  - g12–g15: n0–7 supervisor.
  - Groups 8–11 and 16–31 hold no registers.
  An access to a coprocessor-k register while `cu_en_i[k]` is 0 raises an exception with cause 0x80+k (0x80, 0x81, 0x82).
- R3: An access to a supervisor-class register while `user_mode_i` is 1, with no coprocessor failure, raises an exception with cause 0xA0.
- R4: The coprocessor check comes before the privilege check. A register that needs both coprocessor-0 and supervisor privilege, accessed in user mode with `cu_en_i[0]`=0, yields cause 0x80, not 0xA0.
- R5: Unassigned pairs are treated as supervisor-class. Accessing one in user mode raises cause 0xA0.
- R6: A granted read of an unassigned pair asserts `undef_rd_o` and drives `rdata_o` to zero.
- R7: A granted write to an unassigned pair asserts `wr_drop_o` and leaves `wr_en_o` low.
- R8: Writes to the following (number, group) pairs are never committed: (11,0), (1,1), (7,1), (10,1), (13,1), (14,1), (15,1), (16,1), (5,2), (20,5). A granted write to one of them asserts `wr_drop_o` and leaves `wr_en_o` low. Reads of them follow the ordinary rules.
- R9: When `exc_o` is high, `wr_en_o`, `wr_drop_o` and `undef_rd_o` are all low.
- R10: A granted write to an assigned, unprotected register asserts `wr_en_o`. A granted read of an assigned register returns on `rdata_o` the `rf_rdata_i` value present with the request.
- R11: In supervisor mode with all three coprocessor bits set, every request is granted. User-class registers are granted in user mode whatever the coprocessor bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Access request present this cycle |
| req_write_i | input | 1 | 1 = store to register, 0 = load |
| req_num_i | input | 5 | Register number |
| req_grp_i | input | 5 | Selection group |
| user_mode_i | input | 1 | Status word user-mode flag |
| cu_en_i | input | 3 | Coprocessor-enable bits, bit k for coprocessor k |
| rf_rdata_i | input | 32 | Register file read data for the requested register |
| grant_o | output | 1 | Access accepted |
| wr_en_o | output | 1 | Commit write strobe to the register file |
| wr_drop_o | output | 1 | Granted write was discarded |
| undef_rd_o | output | 1 | Granted read of an unassigned register |
| exc_o | output | 1 | Exception request |
| exc_cause_o | output | 8 | Exception cause code |
| rdata_o | output | 32 | Read result |

## Verification
Directed requests come first. They aim at the dual-permission register with every mix of mode and coprocessor-0 bit, so that a swapped check order shows up as 0xA0 in place of 0x80. They also hit unassigned groups in both modes and the protected-write pairs as both writes and reads, which tells a write ban apart from an access ban. An exhaustive sweep follows, over every number and group, both directions, both modes and three coprocessor patterns (none, all, and only coprocessor-1). This separates the three coprocessor cause codes from one another and catches any misplaced entry in the class map. Idle cycles are mixed in to expose flags that stay set after a request.

// File: rtl/sreg_guard_pkg.sv
package sreg_guard_pkg;

    localparam int CAUSE_W  = 8;
    localparam int CU_N     = 3;
    localparam int CU_IDX_W = $clog2(CU_N);
    localparam int PROHIB_N = 10;

    // Protected write targets, kept as parallel number / group lists
    localparam int PROHIB_NUM [PROHIB_N] = '{11, 1, 7, 10, 13, 14, 15, 16, 5, 20};
    localparam int PROHIB_GRP [PROHIB_N] = '{0, 1, 1, 1, 1, 1, 1, 1, 2, 5};

    typedef enum logic [2:0] {
        CLS_USER,
        CLS_SV,
        CLS_CP0,
        CLS_CP1,
        CLS_CP2,
        CLS_CP0_SV
    } perm_cls_e;

    typedef struct packed {
        logic      defined;
        perm_cls_e cls;
    } perm_t;

    typedef struct packed {
        logic               grant;
        logic               wr_en;
        logic               wr_drop;
        logic               undef_rd;
        logic               exc;
        logic [CAUSE_W-1:0] cause;
    } verdict_t;

endpackage

// File: rtl/sreg_class_map.sv
module sreg_class_map
    import sreg_guard_pkg::*;
#(
    parameter int NUM_W = 5,
    parameter int GRP_W = 5
) (
    input  logic [NUM_W-1:0] num_i,
    input  logic [GRP_W-1:0] grp_i,
    output perm_t            perm_o
);

    int unsigned n;
    int unsigned g;

    always_comb begin
        n = 32'(num_i);
        g = 32'(grp_i);
        perm_o = '{defined: 1'b0, cls: CLS_SV};
        if (g == 0) begin
            if (n <= 5 || (n >= 9 && n <= 11)) perm_o = '{defined: 1'b1, cls: CLS_SV};
            else if (n == 6 || n == 7)         perm_o = '{defined: 1'b1, cls: CLS_CP0};
            else if (n == 8)                   perm_o = '{defined: 1'b1, cls: CLS_CP0_SV};
        end else if (g == 1) begin
            if (n <= 3)       perm_o = '{defined: 1'b1, cls: CLS_USER};
            else if (n <= 15) perm_o = '{defined: 1'b1, cls: CLS_SV};
        end else if (g == 2) begin
            if (n <= 7)       perm_o = '{defined: 1'b1, cls: CLS_SV};
            else if (n == 8)  perm_o = '{defined: 1'b1, cls: CLS_CP1};
            else if (n == 9)  perm_o = '{defined: 1'b1, cls: CLS_CP2};
        end else if (g == 3) begin
            if (n <= 7)       perm_o = '{defined: 1'b1, cls: CLS_SV};
        end else if (g >= 4 && g <= 7) begin
            if (n <= 15)      perm_o = '{defined: 1'b1, cls: CLS_SV};
        end else if (g >= 12 && g <= 15) begin
            if (n <= 7)       perm_o = '{defined: 1'b1, cls: CLS_SV};
        end
    end

endmodule

// File: rtl/sreg_wr_block.sv
module sreg_wr_block
    import sreg_guard_pkg::*;
#(
    parameter int NUM_W = 5,
    parameter int GRP_W = 5
) (
    input  logic [NUM_W-1:0] num_i,
    input  logic [GRP_W-1:0] grp_i,
    output logic             blocked_o
);

    logic [PROHIB_N-1:0] hit;

    for (genvar i = 0; i < PROHIB_N; i++) begin : g_entry
        assign hit[i] = (num_i == NUM_W'(PROHIB_NUM[i])) &&
                        (grp_i == GRP_W'(PROHIB_GRP[i]));
    end

    assign blocked_o = |hit;

endmodule

// File: rtl/sreg_verdict.sv
module sreg_verdict
    import sreg_guard_pkg::*;
#(
    parameter logic [CAUSE_W-1:0] CP_BASE   = 8'h80,
    parameter logic [CAUSE_W-1:0] PIE_CAUSE = 8'hA0
) (
    input  logic            valid_i,
    input  logic            write_i,
    input  logic            user_i,
    input  logic [CU_N-1:0] cu_en_i,
    input  perm_t           perm_i,
    input  logic            blocked_i,
    output verdict_t        verdict_o
);

    logic                cu_need;
    logic [CU_IDX_W-1:0] cu_idx;
    logic                cu_fail;
    logic                sv_fail;

    always_comb begin
        cu_need = 1'b0;
        cu_idx  = '0;
        unique case (perm_i.cls)
            CLS_CP0, CLS_CP0_SV: begin cu_need = 1'b1; cu_idx = CU_IDX_W'(0); end
            CLS_CP1:             begin cu_need = 1'b1; cu_idx = CU_IDX_W'(1); end
            CLS_CP2:             begin cu_need = 1'b1; cu_idx = CU_IDX_W'(2); end
            default:             ;
        endcase
        cu_fail = cu_need && !cu_en_i[cu_idx];
        sv_fail = user_i && (!perm_i.defined || perm_i.cls == CLS_SV ||
                             perm_i.cls == CLS_CP0_SV);

        verdict_o = '0;
        if (valid_i) begin
            if (cu_fail) begin
                verdict_o.exc   = 1'b1;
                verdict_o.cause = CP_BASE + CAUSE_W'(cu_idx);
            end else if (sv_fail) begin
                verdict_o.exc   = 1'b1;
                verdict_o.cause = PIE_CAUSE;
            end else begin
                verdict_o.grant = 1'b1;
                if (write_i) begin
                    if (!perm_i.defined || blocked_i) verdict_o.wr_drop = 1'b1;
                    else                              verdict_o.wr_en   = 1'b1;
                end else begin
                    verdict_o.undef_rd = !perm_i.defined;
                end
            end
        end
    end

endmodule

// File: rtl/sreg_guard.sv
module sreg_guard
    import sreg_guard_pkg::*;
#(
    parameter int                 NUM_W     = 5,
    parameter int                 GRP_W     = 5,
    parameter int                 DATA_W    = 32,
    parameter logic [CAUSE_W-1:0] CP_BASE   = 8'h80,
    parameter logic [CAUSE_W-1:0] PIE_CAUSE = 8'hA0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid_i,
    input  logic               req_write_i,
    input  logic [NUM_W-1:0]   req_num_i,
    input  logic [GRP_W-1:0]   req_grp_i,
    input  logic               user_mode_i,
    input  logic [CU_N-1:0]    cu_en_i,
    input  logic [DATA_W-1:0]  rf_rdata_i,
    output logic               grant_o,
    output logic               wr_en_o,
    output logic               wr_drop_o,
    output logic               undef_rd_o,
    output logic               exc_o,
    output logic [CAUSE_W-1:0] exc_cause_o,
    output logic [DATA_W-1:0]  rdata_o
);

    typedef struct packed {
        verdict_t          v;
        logic [DATA_W-1:0] rdata;
    } st_t;

    perm_t    perm;
    logic     blocked;
    verdict_t vd;
    st_t      st_d, st_q;

    sreg_class_map #(.NUM_W(NUM_W), .GRP_W(GRP_W)) u_map (
        .num_i (req_num_i),
        .grp_i (req_grp_i),
        .perm_o(perm)
    );

    sreg_wr_block #(.NUM_W(NUM_W), .GRP_W(GRP_W)) u_block (
        .num_i    (req_num_i),
        .grp_i    (req_grp_i),
        .blocked_o(blocked)
    );

    sreg_verdict #(.CP_BASE(CP_BASE), .PIE_CAUSE(PIE_CAUSE)) u_verdict (
        .valid_i  (req_valid_i),
        .write_i  (req_write_i),
        .user_i   (user_mode_i),
        .cu_en_i  (cu_en_i),
        .perm_i   (perm),
        .blocked_i(blocked),
        .verdict_o(vd)
    );

    always_comb begin
        st_d   = '0;
        st_d.v = vd;
        if (vd.grant && !req_write_i && !vd.undef_rd) begin
            st_d.rdata = rf_rdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant_o     = st_q.v.grant;
    assign wr_en_o     = st_q.v.wr_en;
    assign wr_drop_o   = st_q.v.wr_drop;
    assign undef_rd_o  = st_q.v.undef_rd;
    assign exc_o       = st_q.v.exc;
    assign exc_cause_o = st_q.v.cause;
    assign rdata_o     = st_q.rdata;

endmodule

// File: rtl/sreg_guard_chk.sv
module sreg_guard_chk #(
    parameter int         DATA_W    = 32,
    parameter logic [7:0] CP_BASE   = 8'h80,
    parameter logic [7:0] PIE_CAUSE = 8'hA0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid_i,
    input logic              user_mode_i,
    input logic [2:0]        cu_en_i,
    input logic              grant_o,
    input logic              wr_en_o,
    input logic              wr_drop_o,
    input logic              undef_rd_o,
    input logic              exc_o,
    input logic [7:0]        exc_cause_o,
    input logic [DATA_W-1:0] rdata_o
);

    p_one_outcome_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ($onehot0({grant_o, exc_o}) && ((grant_o || exc_o) == $past(req_valid_i))));

    p_cu0_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_o && exc_cause_o == CP_BASE) |-> !$past(cu_en_i[0]));

    p_priv_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_o && exc_cause_o == PIE_CAUSE) |-> $past(user_mode_i));

    p_undef_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        undef_rd_o |-> (grant_o && rdata_o == '0));

    p_drop_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_drop_o |-> (grant_o && !wr_en_o));

    p_exc_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |-> (!wr_en_o && !wr_drop_o && !undef_rd_o));

    p_commit_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> grant_o);

    p_full_perm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid_i && !user_mode_i && (&cu_en_i)) |-> grant_o);

endmodule

bind sreg_guard sreg_guard_chk #(
    .DATA_W   (DATA_W),
    .CP_BASE  (CP_BASE),
    .PIE_CAUSE(PIE_CAUSE)
) u_chk (.*);

// File: tb/sim_sreg_guard.sv
module sim_sreg_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_write_i = 1'b0;
    logic [4:0]  req_num_i = '0;
    logic [4:0]  req_grp_i = '0;
    logic        user_mode_i = 1'b0;
    logic [2:0]  cu_en_i = '0;
    logic [31:0] rf_rdata_i = '0;
    logic        grant_o, wr_en_o, wr_drop_o, undef_rd_o, exc_o;
    logic [7:0]  exc_cause_o;
    logic [31:0] rdata_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sreg_guard u0 (.*);

    typedef struct {
        bit          g, w, d, u, e;
        logic [7:0]  c;
        logic [31:0] r;
        string       tag;
    } exp_t;

    exp_t pend;
    bit   have_pend = 0;

    // -1 unassigned, 0 user, 1 supervisor, 2/3/4 coprocessor 0/1/2, 5 cp0 + supervisor
    function automatic int class_of(int n, int g);
        case (g)
            0: begin
                if (n == 8) return 5;
                if (n == 6 || n == 7) return 2;
                if (n <= 11) return 1;
                return -1;
            end
            1: return (n <= 3) ? 0 : ((n <= 15) ? 1 : -1);
            2: begin
                if (n == 8) return 3;
                if (n == 9) return 4;
                return (n <= 7) ? 1 : -1;
            end
            3: return (n <= 7) ? 1 : -1;
            4, 5, 6, 7: return (n <= 15) ? 1 : -1;
            12, 13, 14, 15: return (n <= 7) ? 1 : -1;
            default: return -1;
        endcase
    endfunction

    function automatic bit banned(int n, int g);
        int pairs[$] = '{11 + 0*32, 1 + 1*32, 7 + 1*32, 10 + 1*32, 13 + 1*32,
                         14 + 1*32, 15 + 1*32, 16 + 1*32, 5 + 2*32, 20 + 5*32};
        foreach (pairs[i]) if (pairs[i] == n + g*32) return 1;
        return 0;
    endfunction

    function automatic exp_t model(bit v, bit w, int n, int g, bit u, logic [2:0] cu,
                                   logic [31:0] rf);
        exp_t x;
        int   c;
        int   k;
        x = '{0, 0, 0, 0, 0, 8'h00, 32'h0, "R1"};
        if (!v) return x;
        c = class_of(n, g);
        k = (c == 5) ? 0 : ((c >= 2 && c <= 4) ? c - 2 : -1);
        if (k >= 0 && !cu[k]) begin
            x.e = 1; x.c = 8'h80 + 8'(k);
            x.tag = (c == 5 && u) ? "R4" : "R2";
        end else if (u && (c == 1 || c == 5 || c < 0)) begin
            x.e = 1; x.c = 8'hA0;
            x.tag = (c < 0) ? "R5" : "R3";
        end else begin
            x.g = 1;
            if (w) begin
                if (c < 0)             begin x.d = 1; x.tag = "R7"; end
                else if (banned(n, g)) begin x.d = 1; x.tag = "R8"; end
                else                   begin x.w = 1; x.tag = "R10"; end
            end else if (c < 0) begin
                x.u = 1; x.tag = "R6";
            end else begin
                x.r = rf; x.tag = "R10";
            end
            if (c == 0 && u) x.tag = "R11";
        end
        return x;
    endfunction

    task automatic compare(exp_t x);
        checks++;
        if (grant_o !== x.g || wr_en_o !== x.w || wr_drop_o !== x.d || undef_rd_o !== x.u ||
            exc_o !== x.e || exc_cause_o !== x.c || rdata_o !== x.r) begin
            errors++;
            $display("FAIL %s: got g%0b w%0b d%0b u%0b e%0b c%02h r%08h exp g%0b w%0b d%0b u%0b e%0b c%02h r%08h",
                     x.tag, grant_o, wr_en_o, wr_drop_o, undef_rd_o, exc_o, exc_cause_o, rdata_o,
                     x.g, x.w, x.d, x.u, x.e, x.c, x.r);
        end
    endtask

    // One cycle: check the result of the previous request, then present the next one
    task automatic step(bit v, bit w, int n, int g, bit u, logic [2:0] cu);
        logic [31:0] rf;
        @(negedge clk);
        if (have_pend) compare(pend);
        rf = 32'h8000_0000 | 32'(g << 8) | 32'(n) | 32'(checks << 12);
        req_valid_i = v; req_write_i = w; req_num_i = 5'(n); req_grp_i = 5'(g);
        user_mode_i = u; cu_en_i = cu; rf_rdata_i = rf;
        pend = model(v, w, n, g, u, cu, rf);
        have_pend = 1;
    endtask

    initial begin
        exp_t zero;
        zero = '{0, 0, 0, 0, 0, 8'h00, 32'h0, "R1 reset"};
        req_valid_i = 1'b1;
        repeat (3) @(negedge clk);
        compare(zero);                       // R1: outputs held at zero in reset
        req_valid_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 3'b000);         // R1 idle
        // R4: dual-permission register, order of checks
        step(1, 0, 8, 0, 1, 3'b000);
        step(1, 0, 8, 0, 1, 3'b001);
        step(1, 1, 8, 0, 0, 3'b000);
        step(1, 1, 8, 0, 0, 3'b001);
        // R2: each coprocessor cause
        step(1, 0, 8, 2, 0, 3'b000);
        step(1, 0, 9, 2, 0, 3'b010);
        step(1, 0, 6, 0, 1, 3'b110);
        // R5 / R6 / R7: unassigned pairs
        step(1, 0, 0, 20, 1, 3'b111);
        step(1, 0, 0, 9, 0, 3'b111);
        step(1, 1, 31, 3, 0, 3'b111);
        // R8: protected writes and reads of the same pairs
        step(1, 1, 11, 0, 0, 3'b111);
        step(1, 0, 11, 0, 0, 3'b111);
        step(1, 1, 1, 1, 1, 3'b000);
        step(1, 0, 1, 1, 1, 3'b000);
        step(1, 1, 20, 5, 0, 3'b111);
        // R10 / R11
        step(1, 1, 12, 4, 0, 3'b000);
        step(1, 1, 2, 1, 1, 3'b000);
        // Exhaustive sweep with idle cycles mixed in
        for (int g = 0; g < 32; g++)
            for (int n = 0; n < 32; n++)
                for (int m = 0; m < 12; m++) begin
                    logic [2:0] cu;
                    cu = (m % 3 == 0) ? 3'b000 : ((m % 3 == 1) ? 3'b111 : 3'b010);
                    step((n + m) % 7 != 6, m[2], n, g, m[3], cu);
                end
        step(0, 0, 0, 0, 0, 3'b000);
        step(0, 0, 0, 0, 0, 3'b000);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule